// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations for a 32-bit virtual address space that uses 4 KB pages. Each entry holds a virtual page number as its tag and a page frame number as its payload. A lookup compares the incoming page number against every entry at once. Hit and the physical address come back combinationally in the same cycle, so a load or fetch pipeline can use the result without an extra stage.

After a miss, the surrounding logic fetches the translation and installs it through the fill port. When the cache is full, the entry that was used longest ago is replaced. Software or control logic can drop a single stale translation by page number, for example after its protection changes. It can also clear the whole cache in one cycle, for example on a switch between processes. The entry count is a parameter with a default of 16.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_en` is high and a valid entry's tag equals `lk_va[31:12]`, `lk_hit` is high in that same cycle with no clock edge in between; otherwise `lk_hit` is low.
- R2: On a hit, `lk_pa[31:12]` is the entry's page frame number and `lk_pa[11:0]` equals `lk_va[11:0]`.
- R3: After a cycle with `fill_en` high, a lookup of `fill_vpn` in the next cycle hits and returns `fill_pfn`.
- R4: A fill whose page number is not present goes into the lowest-index invalid entry while any entry is invalid; no valid translation is displaced in that case.
- R5: When all entries are valid, a fill of a new page number replaces the least recently used entry. A lookup hit or a fill makes its entry the most recently used.
- R6: A fill for a page number that is already present overwrites that entry, so no two valid entries share a tag.
- R7: `inv_en` clears only the valid entry whose tag equals `inv_vpn`, and it leaves every other entry hitting as before.
- R8: `flush_en` clears every entry in one cycle, so no lookup hits in the following cycle.
- R9: When `flush_en` and `fill_en` are high in the same cycle, the flush applies first, and only the filled translation remains afterwards.
- R10: After reset, every entry is invalid.
- R11: When `inv_en` and `fill_en` are high in the same cycle, the invalidate applies first, and the fill then lands (also when both name the same page).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found (combinational) |
| lk_pa | output | 32 | Physical address: frame number and page offset |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Page frame number to install |
| inv_en | input | 1 | Invalidate one entry |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| flush_en | input | 1 | Invalidate all entries |

## Verification
Some properties are checked on every cycle:
- No two entries ever match one lookup.
- A translation filled in one cycle is returned with its frame number and untouched offset in the next cycle.
- An invalidated page misses in the next cycle.
- Nothing hits after a flush, except a fill made in the same cycle as that flush.

Which entry a fill displaces depends on the history of hits and fills. Only the bench's scenarios can show this: the directed sequences that fill the cache, touch one entry and then overflow it, and the long random mix that a recency-ordered reference model checks on every lookup.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ENTRIES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_en,
  input  logic [VA_W-1:0]      lk_va,
  output logic                 lk_hit,
  output logic [PA_W-1:0]      lk_pa,
  input  logic                 fill_en,
  input  logic [VA_W-PAGE_W-1:0] fill_vpn,
  input  logic [PA_W-PAGE_W-1:0] fill_pfn,
  input  logic                 inv_en,
  input  logic [VA_W-PAGE_W-1:0] inv_vpn,
  input  logic                 flush_en
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PFN_W = PA_W - PAGE_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid, lk_match, keep_v, fill_match, valid_nxt;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PFN_W-1:0]   pfn [ENTRIES];
  logic [IDX_W-1:0]   age [ENTRIES];
  logic [IDX_W-1:0]   hit_idx, victim, touch_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic               any_free, touch_en;

  wire [VPN_W-1:0] lk_vpn = lk_va[VA_W-1:PAGE_W];

  always_comb begin
    hit_idx = '0;
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i]   = valid[i] && (tag[i] == lk_vpn);
      keep_v[i]     = !flush_en && valid[i] && !(inv_en && tag[i] == inv_vpn);
      fill_match[i] = keep_v[i] && (tag[i] == fill_vpn);
      if (lk_match[i]) begin
        hit_idx = IDX_W'(i);
        hit_pfn = pfn[i];
      end
    end
  end

  assign lk_hit = lk_en && (|lk_match);
  assign lk_pa  = {hit_pfn, lk_va[PAGE_W-1:0]};

  always_comb begin
    victim   = '0;
    any_free = 1'b0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (!keep_v[i]) begin
        victim   = IDX_W'(i);
        any_free = 1'b1;
      end
    if (!any_free)
      for (int i = 0; i < ENTRIES; i++)
        if (age[i] == IDX_W'(ENTRIES-1)) victim = IDX_W'(i);
    for (int i = 0; i < ENTRIES; i++)
      if (fill_match[i]) victim = IDX_W'(i);
  end

  always_comb begin
    valid_nxt = keep_v;
    if (fill_en) valid_nxt[victim] = 1'b1;
  end

  assign touch_en  = fill_en || lk_hit;
  assign touch_idx = fill_en ? victim : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else begin
      valid <= valid_nxt;
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == touch_idx) age[i] <= '0;
          else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag[victim] <= fill_vpn;
      pfn[victim] <= fill_pfn;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ENTRIES = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_en,
  input logic [VA_W-1:0]          lk_va,
  input logic                     lk_hit,
  input logic [PA_W-1:0]          lk_pa,
  input logic                     fill_en,
  input logic [VA_W-PAGE_W-1:0]   fill_vpn,
  input logic [PA_W-PAGE_W-1:0]   fill_pfn,
  input logic                     inv_en,
  input logic [VA_W-PAGE_W-1:0]   inv_vpn,
  input logic                     flush_en,
  input logic [ENTRIES-1:0]       lk_match
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PFN_W = PA_W - PAGE_W;

  logic             p_fill, p_inv, p_flush;
  logic [VPN_W-1:0] p_fill_vpn, p_inv_vpn;
  logic [PFN_W-1:0] p_fill_pfn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_fill <= 1'b0; p_inv <= 1'b0; p_flush <= 1'b0;
      p_fill_vpn <= '0; p_inv_vpn <= '0; p_fill_pfn <= '0;
    end else begin
      p_fill <= fill_en; p_inv <= inv_en; p_flush <= flush_en;
      p_fill_vpn <= fill_vpn; p_inv_vpn <= inv_vpn; p_fill_pfn <= fill_pfn;
    end
  end

  wire [VPN_W-1:0] cur_vpn = lk_va[VA_W-1:PAGE_W];

  a_r6_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r3_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (p_fill && lk_en && cur_vpn == p_fill_vpn) |->
      (lk_hit && lk_pa == {p_fill_pfn, lk_va[PAGE_W-1:0]}));   // R2 too

  a_r7_inv_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (p_inv && !(p_fill && p_fill_vpn == p_inv_vpn) && cur_vpn == p_inv_vpn) |-> !lk_hit);

  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (p_flush && !p_fill) |-> !lk_hit);

  a_r9_flush_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (p_flush && p_fill && cur_vpn != p_fill_vpn) |-> !lk_hit);

  a_r1_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> !lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .inv_en(inv_en),
  .inv_vpn(inv_vpn), .flush_en(flush_en), .lk_match(lk_match));

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        inv_en = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        flush_en = 1'b0;

  int checks = 0;
  int errors = 0;

  logic        m_v   [N];
  logic [19:0] m_tag [N];
  logic [19:0] m_pfn [N];
  int          m_use [N];
  int          now = 0;

  always #4 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_en(flush_en));

  function automatic int find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    int k = find(va[31:12]);
    return (k < 0) ? 32'h0 : {m_pfn[k], va[11:0]};
  endfunction

  task automatic model_clock();
    int k;
    now++;
    if (flush_en) for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    if (inv_en) begin
      k = find(inv_vpn);
      if (k >= 0) m_v[k] = 1'b0;
    end
    if (fill_en) begin
      k = find(fill_vpn);
      if (k < 0)
        for (int i = N-1; i >= 0; i--) if (!m_v[i]) k = i;
      if (k < 0) begin
        k = 0;
        for (int i = 1; i < N; i++) if (m_use[i] < m_use[k]) k = i;
      end
      m_v[k] = 1'b1; m_tag[k] = fill_vpn; m_pfn[k] = fill_pfn; m_use[k] = now;
    end else if (lk_en && pre_hit >= 0) begin
      m_use[pre_hit] = now;
    end
  endtask

  int pre_hit = -1;

  task automatic check(input logic ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input string req);
    logic eh;
    #2;
    pre_hit = lk_en ? find(lk_va[31:12]) : -1;
    if (lk_en) begin
      eh = (pre_hit >= 0);
      check(lk_hit == eh, req, {32'h0, lk_hit}, {32'h0, eh});
      if (eh) check(lk_pa == exp_pa(lk_va), {req, "/R2"}, {1'b0, lk_pa}, {1'b0, exp_pa(lk_va)});
    end
    @(posedge clk);
    model_clock();
    @(negedge clk);
    lk_en = 0; fill_en = 0; inv_en = 0; flush_en = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input string req, input logic want);
    lk_en = 1; lk_va = {vpn, off};
    #2;
    check(lk_hit == want, req, {32'h0, lk_hit}, {32'h0, want});
    #0;
    cyc(req);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p);
    fill_en = 1; fill_vpn = v; fill_pfn = p;
    cyc("R3");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = 0; m_pfn[i] = 0; m_use[i] = -N + i; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: empty after reset
    look(20'h00000, 12'h000, "R10", 1'b0);
    look(20'h12345, 12'h678, "R10", 1'b0);
    // R1 R3 R2
    fill(20'h12345, 20'hABCDE);
    look(20'h12345, 12'h678, "R1", 1'b1);
    check(exp_pa({20'h12345, 12'h678}) == 32'hABCDE678, "R2", {1'b0, exp_pa({20'h12345, 12'h678})}, {1'b0, 32'hABCDE678});
    // R6 overwrite
    fill(20'h12345, 20'h00042);
    look(20'h12345, 12'hFFF, "R6", 1'b1);
    inv_en = 1; inv_vpn = 20'h12345; cyc("R7");
    look(20'h12345, 12'h000, "R6", 1'b0);
    // R5 LRU
    flush_en = 1; cyc("R8");
    for (int k = 0; k < N; k++) fill(20'h00100 + 20'(k), 20'h80000 + 20'(k));
    look(20'h00100, 12'h010, "R5", 1'b1);
    fill(20'h00200, 20'h90000);
    look(20'h00101, 12'h000, "R5", 1'b0);
    look(20'h00100, 12'h000, "R5", 1'b1);
    // R4 invalid slot preferred over LRU
    inv_en = 1; inv_vpn = 20'h00105; cyc("R7");
    fill(20'h00300, 20'h90300);
    look(20'h00102, 12'h000, "R4", 1'b1);
    look(20'h00300, 12'h000, "R4", 1'b1);
    // R7 selective
    inv_en = 1; inv_vpn = 20'h0010A; cyc("R7");
    look(20'h0010A, 12'h000, "R7", 1'b0);
    look(20'h0010B, 12'h000, "R7", 1'b1);
    // R8 flush
    flush_en = 1; cyc("R8");
    look(20'h00100, 12'h000, "R8", 1'b0);
    look(20'h0010B, 12'h000, "R8", 1'b0);
    // R9 flush with fill
    fill(20'h00111, 20'h1);
    flush_en = 1; fill_en = 1; fill_vpn = 20'h00400; fill_pfn = 20'h44444; cyc("R9");
    look(20'h00400, 12'h123, "R9", 1'b1);
    look(20'h00111, 12'h000, "R9", 1'b0);
    // R11 invalidate with fill, same page
    fill(20'h00500, 20'h5);
    inv_en = 1; inv_vpn = 20'h00500; fill_en = 1; fill_vpn = 20'h00500; fill_pfn = 20'h55555; cyc("R11");
    look(20'h00500, 12'h0AB, "R11", 1'b1);
    // random mix, checked against the model on every lookup
    for (int n = 0; n < 4000; n++) begin
      lk_en = ($urandom_range(0, 9) != 0);
      lk_va = {20'h7F000 + 20'($urandom_range(0, 23)), 12'($urandom)};
      fill_en = ($urandom_range(0, 9) < 3);
      fill_vpn = 20'h7F000 + 20'($urandom_range(0, 23));
      fill_pfn = 20'($urandom);
      inv_en = ($urandom_range(0, 9) == 0);
      inv_vpn = 20'h7F000 + 20'($urandom_range(0, 23));
      flush_en = ($urandom_range(0, 49) == 0);
      cyc("R1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule